// File: doc/BRIEF.md
# Sticky Event Status Register with Masked Interrupt

This block gathers single-bit event signals that arrive from the line side with no timing relation to the host clock. It catches each one in a sticky status bit. A host on a simple parallel port reads those bits and clears any chosen subset by writing ones to them. Bits the host leaves at zero in the write are untouched, so one piece of software can service one event without disturbing another.

A second register holds one enable per status bit. The active-low interrupt output is driven low while any enabled status bit is set. It returns high once the host has cleared every enabled bit that is pending.

If an event lands in the same cycle as a host clear of its bit, the event wins. Polled software can therefore use a write, read, write sequence: it clears, reads back, ANDs the result with its clear mask, and writes again. Any occurrence that arrived in between is then caught rather than lost.

Top module: `evt_status_top`

## Requirements
- R1: After synchronous reset, every status bit and every mask bit is 0, `irq_n` is 1 and `rd_data` is 0.
- R2: A rising edge on an `evt_in` bit sets the matching status bit. A level held high sets it only once, so after a clear the bit stays 0 until the input falls and rises again.
- R3: A write with `addr` = 0 clears exactly the status bits whose `wr_data` bit is 1. All other status bits keep their value.
- R4: When an event edge and a host clear reach the same status bit on the same clock edge, the bit ends up set.
- R5: A write with `addr` = 1 loads `wr_data` into the mask register. A read at `addr` = 1 returns that value.
- R6: `irq_n` goes low one clock after any status bit whose mask bit is 1 is set. Set bits whose mask bit is 0 never pull it low.
- R7: `irq_n` returns high one clock after the last status bit that has its mask bit at 1 is cleared, or after its mask bit is cleared.
- R8: A read (`rd_en` = 1) loads `rd_data` on the next clock with the selected register (0 = status, 1 = mask). It changes neither register nor `irq_n`. While `rd_en` is 0, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | N_EVT | Asynchronous event lines, one per status bit |
| addr | input | 1 | Register select: 0 status, 1 mask |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | N_EVT | Write data; for status, ones select the bits to clear |
| rd_data | output | N_EVT | Registered read data |
| irq_n | output | 1 | Registered interrupt, active low |

## Verification
The assertions assume that `wr_en` and `rd_en` are low during reset and that no write is issued in the cycle reset is released. They also assume that each event line stays at one level for at least two host clocks, so the synchronizer produces one clean edge per event. The stimulus drives every input on the falling clock edge. It holds each event level for several cycles and places the colliding event and clear on a computed edge, counting the synchronizer stages. A sweep covers every combination of mask and event pattern for four event bits.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int N_EVT = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_async,
  output logic [N_EVT-1:0] evt_rise
);
  localparam int CHAIN = STAGES + 1;

  logic [N_EVT-1:0] chain_q [CHAIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < CHAIN; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= evt_async;
      for (int s = 1; s < CHAIN; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  // one pulse per synchronized rising edge
  genvar g;
  generate
    for (g = 0; g < N_EVT; g++) begin : g_edge
      assign evt_rise[g] = chain_q[STAGES-1][g] & ~chain_q[STAGES][g];
    end
  endgenerate

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_rise) |=> ((evt_rise & $past(evt_rise)) == '0));
endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] set_vec,
  input  logic             clr_en,
  input  logic [N_EVT-1:0] clr_vec,
  output logic [N_EVT-1:0] status
);
  logic [N_EVT-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_vec : '0;

  genvar g;
  generate
    for (g = 0; g < N_EVT; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)             status[g] <= 1'b0;
        else if (set_vec[g]) status[g] <= 1'b1;
        else if (clr_eff[g]) status[g] <= 1'b0;
      end
    end
  endgenerate

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R3
  clear_only_selected_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status) & ~status & ~$past(clr_eff)) == '0));
  // R2
  set_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [N_EVT-1:0] mask_wdata,
  input  logic [N_EVT-1:0] status,
  output logic [N_EVT-1:0] mask_q,
  output logic             irq_n
);
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(status & mask_q);
  end

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(mask_wdata)));
  // R6
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status & mask_q)) |=> !irq_n);
  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(status & mask_q)) |=> irq_n);
endmodule

// File: rtl/evt_status_top.sv
module evt_status_top
  import evt_status_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [N_EVT-1:0] wr_data,
  output logic [N_EVT-1:0] rd_data,
  output logic             irq_n
);
  logic [N_EVT-1:0] rise;
  logic [N_EVT-1:0] status;
  logic [N_EVT-1:0] mask_q;
  logic             clr_en;
  logic             mask_we;

  assign clr_en  = wr_en && (reg_sel_e'(addr) == SEL_STATUS);
  assign mask_we = wr_en && (reg_sel_e'(addr) == SEL_MASK);

  evt_edge_sync #(.N_EVT(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .evt_async(evt_in), .evt_rise(rise)
  );

  evt_sticky_bank #(.N_EVT(N_EVT)) u_bank (
    .clk(clk), .rst(rst), .set_vec(rise), .clr_en(clr_en),
    .clr_vec(wr_data), .status(status)
  );

  evt_irq_gate #(.N_EVT(N_EVT)) u_irq (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(wr_data),
    .status(status), .mask_q(mask_q), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en)
      rd_data <= (reg_sel_e'(addr) == SEL_MASK) ? mask_q : status;
  end

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/evt_status_top_test.sv
module evt_status_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_in = '0;
  logic         addr = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;
  logic         irq_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_status_top #(.N_EVT(N)) uut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [N-1:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, v2;
    logic irq_before;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", irq_n, 1);
    check("R1 rd_data", rd_data, 0);
    rd(1'b0, v); check("R1 status", v, 0);
    rd(1'b1, v); check("R1 mask", v, 0);

    // R5 mask write and readback
    wr(1'b1, 4'hA); rd(1'b1, v); check("R5 mask A", v, 'hA);
    wr(1'b1, 4'h5); rd(1'b1, v); check("R5 mask 5", v, 'h5);

    // R3 R6 R7 sweep over every mask and event pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        wr(1'b1, m[N-1:0]);
        evt_in = p[N-1:0]; idle(4);
        evt_in = '0; idle(4);
        rd(1'b0, v); check("R2 latched", v, p);
        check("R6 irq_n", irq_n, ((p & m) != 0) ? 0 : 1);
        wr(1'b0, m[N-1:0]); @(negedge clk);
        rd(1'b0, v); check("R3 partial clear", v, p & ~m & 'hF);
        check("R7 irq release", irq_n, 1);
        wr(1'b0, 4'hF);
      end
    end

    // R7 release by clearing the mask bit
    wr(1'b1, 4'h2); evt_in = 4'h2; idle(4); evt_in = '0; idle(4);
    check("R6 irq set", irq_n, 0);
    wr(1'b1, 4'h0); @(negedge clk);
    check("R7 mask release", irq_n, 1);
    wr(1'b0, 4'hF);

    // R2 held level sets only once
    evt_in = 4'h1; idle(5);
    wr(1'b0, 4'h1); idle(5);
    rd(1'b0, v); check("R2 level once", v, 0);
    evt_in = '0; idle(4);

    // R4 set and clear on the same edge
    evt_in = 4'h8; idle(4); evt_in = '0; idle(4);
    evt_in = 4'h8;         // sampled at edge k
    @(negedge clk);        // after k
    @(negedge clk);        // after k+1, rise pulse active now
    wr(1'b0, 4'h8);        // clear lands on edge k+2 with the set
    evt_in = '0; idle(2);
    rd(1'b0, v); check("R4 set wins", v, 'h8);
    wr(1'b0, 4'hF); idle(1);

    // R8 reads have no side effect
    wr(1'b1, 4'h4); evt_in = 4'h6; idle(4); evt_in = '0; idle(4);
    irq_before = irq_n;
    rd(1'b0, v); rd(1'b0, v2);
    check("R8 read stable", v2, v);
    check("R8 read value", v, 'h6);
    check("R8 irq unchanged", irq_n, irq_before);
    idle(3);
    check("R8 rd_data holds", rd_data, 'h6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule